// File: doc/BRIEF.md
# CAN Controller Register and Interrupt Block

This block is the register file that sits between a 32-bit register bus and the protocol engine of a CAN controller. Software uses it to set the operating mode, program the bit timing and error counters, and issue commands. It reads back live engine status and the details of the most recent bus error. Engine events become sticky interrupt flags, and an enable mask turns them into one level interrupt line. The bit engine, the message buffer memory and acceptance filtering sit outside this block and connect through its engine-side ports.

The controller leaves reset in its reset (configuration) mode. Bit timing, the error counters and the sleep bit can be written only while the reset-mode bit is set. Command writes do not store anything. Each command bit becomes a single-cycle strobe toward the engine, and a few commands also act on status held here. Interrupt flags are cleared by writing ones to them. An engine event that arrives in the same cycle as a clear takes priority over the clear.

Reads are combinational from `bus_addr`. A write takes effect on the rising clock edge where `bus_we` is high.

Top module: `canc_csr`

## Requirements
- R1: After reset the registers read as follows: mode (0x00) = 0x01, status (0x08) = 0x0000003C, interrupt flags (0x0C) = 0, interrupt enable (0x10) = 0, bit timing (0x14) = 0, error counters (0x1C) = 0. `irq_o` is low and `cmd_pulse_o` is zero.
- R2: The mode register uses these bits: bit0 reset mode, bit1 listen-only, bit2 loopback, bit3 single-filter select, bit4 sleep. Bits 3:0 take the written value on any write. Bit4 changes only when bit0 was already 1 before the write.
- R3: The bit-timing register at 0x14 stores all 32 written bits when bit0 of the mode register is 1. At any other time a write to it is ignored.
- R4: A write to 0x04 drives the written bits [5:0] onto `cmd_pulse_o` for exactly one cycle, the cycle after the write edge. The bits are: 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-receive, 5 bus-off. Address 0x04 always reads as 0.
- R5: A high `evt_i[k]` sets interrupt flag k (0 receive, 1 transmit done, 2 error warning, 3 overrun, 4 wakeup, 5 error passive, 6 arbitration lost, 7 bus error). The flag stays set until software clears it.
- R6: Writing 0x0C clears every flag whose written bit is 1 and leaves the other flags unchanged. If an event arrives in the same cycle as the clear, its flag stays set.
- R7: `irq_o` is high exactly when some flag and its matching bit in the enable register (0x10) are both 1.
- R8: Status bits [7:2] are `eng_live_i[5:0]` sampled one cycle earlier. The bits are: 2 transmit buffer ready, 3 transmit complete, 4 receiving, 5 transmitting, 6 error status, 7 bus-off.
- R9: Status bit0 (receive ready) is set by `evt_i[0]`. It is cleared by a release command only when `eng_rx_more_i` is 0. A receive event in the same cycle as a release leaves it set.
- R10: Status bit1 (overrun) is set by `evt_i[3]` and cleared by the clear-overrun command.
- R11: On `evt_i[7]` the status register captures the error details. `err_seg_i` goes to bits [20:16]. `err_dir_i` goes to bit 21, where 0 means the error happened while transmitting. `err_type_i` goes to bits [23:22], coded 0 bit, 1 form, 2 stuff, 3 other. These bits hold their value until the next bus error.
- R12: The error-counter register holds the transmit count in bits [7:0] and the receive count in bits [23:16]; the same values appear on `tec_o` and `rec_o`. A write to 0x1C while mode bit0 is 1 loads both counts, so writing zero clears them both; at other times the write is ignored. `ec_load_i` loads `ec_tx_i` and `ec_rx_i` into the counts, and a software write that is accepted in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_i | input | 8 | Engine event strobes, one per interrupt flag |
| eng_live_i | input | 6 | Live engine status for status bits [7:2] |
| eng_rx_more_i | input | 1 | Another received message is waiting |
| err_seg_i | input | 5 | Frame segment of the current bus error |
| err_dir_i | input | 1 | Error direction, 0 = transmitting |
| err_type_i | input | 2 | Error type code |
| ec_load_i | input | 1 | Engine load strobe for the error counts |
| ec_tx_i | input | 8 | New transmit error count |
| ec_rx_i | input | 8 | New receive error count |
| mode_o | output | 5 | Mode register contents |
| btime_o | output | 32 | Bit-timing register contents |
| cmd_pulse_o | output | 6 | Single-cycle command strobes |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the engine holds `ec_load_i` low whenever it is not updating the counts. They also assume that `evt_i` bits are strobes sampled on the clock edge, so a bit that stays high keeps setting its flag. The stimulus drives every input from the falling edge and keeps each input pulse to a single cycle. The engine load and the bit-timing and counter writes happen only in the mode the test intends, so each lock property sees both its locked and unlocked cases.

// File: rtl/canc_pkg.sv
package canc_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int MODE_W  = 5;
  localparam int CMD_W   = 6;
  localparam int IRQ_W   = 8;
  localparam int LIVE_W  = 6;
  localparam int EC_W    = 8;
  localparam int SEG_W   = 5;
  localparam int ETYPE_W = 2;
  localparam int ECODE_W = ETYPE_W + 1 + SEG_W;
  localparam int ECODE_LSB = 16;
  localparam int EC_RX_LSB = 16;

  localparam logic [ADDR_W-1:0] A_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] A_CMD  = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] A_IFLG = 8'h0C;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h10;
  localparam logic [ADDR_W-1:0] A_BTIM = 8'h14;
  localparam logic [ADDR_W-1:0] A_ECNT = 8'h1C;

  localparam int MB_RST   = 0;
  localparam int MB_SLEEP = 4;
  localparam logic [MODE_W-1:0] MODE_RST_VAL = 5'h01;

  localparam int CB_REL    = 2;
  localparam int CB_CLROVR = 3;

  localparam int IB_RX   = 0;
  localparam int IB_OVR  = 3;
  localparam int IB_BERR = 7;

  localparam logic [LIVE_W-1:0] LIVE_RST_VAL = 6'b001111;

  // Sticky flag update: surviving flags plus new events (events win).
  function automatic logic [IRQ_W-1:0] flag_next(input logic [IRQ_W-1:0] cur,
                                                  input logic [IRQ_W-1:0] evt,
                                                  input logic [IRQ_W-1:0] clr);
    return (cur & ~clr) | evt;
  endfunction

  function automatic logic [ECODE_W-1:0] ecode_pack(input logic [ETYPE_W-1:0] etype,
                                                     input logic dir,
                                                     input logic [SEG_W-1:0] seg);
    return {etype, dir, seg};
  endfunction

  function automatic logic [REG_W-1:0] ecnt_pack(input logic [EC_W-1:0] tx,
                                                  input logic [EC_W-1:0] rx);
    logic [REG_W-1:0] r;
    r = '0;
    r[EC_W-1:0] = tx;
    r[EC_RX_LSB +: EC_W] = rx;
    return r;
  endfunction
endpackage

// File: rtl/canc_cmd_pulse.sv
module canc_cmd_pulse #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] pulse_o
);
  // Registered strobes: one cycle wide, glitch-free toward the engine.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= '0;
    else        pulse_o <= wr_stb ? wr_bits : '0;
  end
endmodule

// File: rtl/canc_irq_ctrl.sv
module canc_irq_ctrl
  import canc_pkg::*;
#(
  parameter int N = IRQ_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_bits,
  input  logic         en_stb,
  input  logic [N-1:0] en_bits,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] clr_eff;
  logic [N-1:0] flag_nx;

  assign clr_eff = clr_stb ? clr_bits : '0;
  assign flag_nx = flag_next(flag_o, evt_i, clr_eff);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[i] <= 1'b0;
      else        flag_o[i] <= flag_nx[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_o <= '0;
    else if (en_stb) en_o <= en_bits;
  end

  assign irq_o = |(flag_o & en_o);
endmodule

// File: rtl/canc_stat_reg.sv
module canc_stat_reg
  import canc_pkg::*;
#(
  parameter int LW = LIVE_W,
  parameter int SW = SEG_W,
  parameter int TW = ETYPE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_evt,
  input  logic             ovr_evt,
  input  logic             berr_evt,
  input  logic             rel_cmd,
  input  logic             clr_ovr_cmd,
  input  logic             rx_more,
  input  logic [LW-1:0]    live_i,
  input  logic [SW-1:0]    seg_i,
  input  logic             dir_i,
  input  logic [TW-1:0]    type_i,
  output logic [REG_W-1:0] stat_o
);
  localparam int LO_W  = LW + 2;
  localparam int CW    = TW + 1 + SW;
  localparam int MID_W = ECODE_LSB - LO_W;
  localparam int HI_W  = REG_W - ECODE_LSB - CW;

  logic          rx_rdy_q;
  logic          ovr_q;
  logic [LW-1:0] live_q;
  logic [CW-1:0] ecode_q;
  logic          rel_clears;

  assign rel_clears = rel_cmd && !rx_more;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy_q <= 1'b0;
      ovr_q    <= 1'b0;
      live_q   <= LIVE_RST_VAL;
      ecode_q  <= '0;
    end else begin
      live_q <= live_i;
      if (rx_evt)          rx_rdy_q <= 1'b1;
      else if (rel_clears) rx_rdy_q <= 1'b0;
      if (ovr_evt)          ovr_q <= 1'b1;
      else if (clr_ovr_cmd) ovr_q <= 1'b0;
      if (berr_evt) ecode_q <= ecode_pack(type_i, dir_i, seg_i);
    end
  end

  assign stat_o = {{HI_W{1'b0}}, ecode_q, {MID_W{1'b0}}, live_q, ovr_q, rx_rdy_q};
endmodule

// File: rtl/canc_csr.sv
module canc_csr
  import canc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [IRQ_W-1:0]   evt_i,
  input  logic [LIVE_W-1:0]  eng_live_i,
  input  logic               eng_rx_more_i,
  input  logic [SEG_W-1:0]   err_seg_i,
  input  logic               err_dir_i,
  input  logic [ETYPE_W-1:0] err_type_i,
  input  logic               ec_load_i,
  input  logic [EC_W-1:0]    ec_tx_i,
  input  logic [EC_W-1:0]    ec_rx_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic [REG_W-1:0]   btime_o,
  output logic [CMD_W-1:0]   cmd_pulse_o,
  output logic [EC_W-1:0]    tec_o,
  output logic [EC_W-1:0]    rec_o,
  output logic               irq_o
);
  // Named decode strobes.
  logic wr_mode_stb, wr_cmd_stb, wr_iflg_stb, wr_ien_stb, wr_btim_stb, wr_ecnt_stb;
  logic in_cfg;
  logic cmd_rel_now, cmd_clrovr_now;

  logic [MODE_W-1:0] mode_q;
  logic [REG_W-1:0]  btime_q;
  logic [EC_W-1:0]   tec_q, rec_q;
  logic [IRQ_W-1:0]  flag_q, en_q;
  logic [REG_W-1:0]  stat_q;

  assign wr_mode_stb = bus_we && (bus_addr == A_MODE);
  assign wr_cmd_stb  = bus_we && (bus_addr == A_CMD);
  assign wr_iflg_stb = bus_we && (bus_addr == A_IFLG);
  assign wr_ien_stb  = bus_we && (bus_addr == A_IEN);
  assign wr_btim_stb = bus_we && (bus_addr == A_BTIM);
  assign wr_ecnt_stb = bus_we && (bus_addr == A_ECNT);
  assign in_cfg      = mode_q[MB_RST];

  assign cmd_rel_now    = wr_cmd_stb && bus_wdata[CB_REL];
  assign cmd_clrovr_now = wr_cmd_stb && bus_wdata[CB_CLROVR];

  // Mode register: sleep bit locked outside configuration mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST_VAL;
    end else if (wr_mode_stb) begin
      mode_q[MB_SLEEP-1:0] <= bus_wdata[MB_SLEEP-1:0];
      if (in_cfg) mode_q[MB_SLEEP] <= bus_wdata[MB_SLEEP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      btime_q <= '0;
    else if (wr_btim_stb && in_cfg) btime_q <= bus_wdata;
  end

  // Error counts: accepted software write beats engine load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else if (wr_ecnt_stb && in_cfg) begin
      tec_q <= bus_wdata[EC_W-1:0];
      rec_q <= bus_wdata[EC_RX_LSB +: EC_W];
    end else if (ec_load_i) begin
      tec_q <= ec_tx_i;
      rec_q <= ec_rx_i;
    end
  end

  canc_cmd_pulse #(.N(CMD_W)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_cmd_stb),
    .wr_bits (bus_wdata[CMD_W-1:0]),
    .pulse_o (cmd_pulse_o)
  );

  canc_irq_ctrl #(.N(IRQ_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .clr_stb  (wr_iflg_stb),
    .clr_bits (bus_wdata[IRQ_W-1:0]),
    .en_stb   (wr_ien_stb),
    .en_bits  (bus_wdata[IRQ_W-1:0]),
    .flag_o   (flag_q),
    .en_o     (en_q),
    .irq_o    (irq_o)
  );

  canc_stat_reg #(.LW(LIVE_W), .SW(SEG_W), .TW(ETYPE_W)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_evt      (evt_i[IB_RX]),
    .ovr_evt     (evt_i[IB_OVR]),
    .berr_evt    (evt_i[IB_BERR]),
    .rel_cmd     (cmd_rel_now),
    .clr_ovr_cmd (cmd_clrovr_now),
    .rx_more     (eng_rx_more_i),
    .live_i      (eng_live_i),
    .seg_i       (err_seg_i),
    .dir_i       (err_dir_i),
    .type_i      (err_type_i),
    .stat_o      (stat_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata[MODE_W-1:0] = mode_q;
      A_STAT:  bus_rdata = stat_q;
      A_IFLG:  bus_rdata[IRQ_W-1:0] = flag_q;
      A_IEN:   bus_rdata[IRQ_W-1:0] = en_q;
      A_BTIM:  bus_rdata = btime_q;
      A_ECNT:  bus_rdata = ecnt_pack(tec_q, rec_q);
      default: bus_rdata = '0;
    endcase
  end

  assign mode_o  = mode_q;
  assign btime_o = btime_q;
  assign tec_o   = tec_q;
  assign rec_o   = rec_q;
endmodule

// File: rtl/canc_csr_chk.sv
module canc_csr_chk
  import canc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [IRQ_W-1:0]  evt_i,
  input logic              ec_load_i,
  input logic              mode_rst,
  input logic              mode_sleep,
  input logic [REG_W-1:0]  btime_o,
  input logic [CMD_W-1:0]  cmd_pulse_o,
  input logic [EC_W-1:0]   tec_o,
  input logic [EC_W-1:0]   rec_o,
  input logic              irq_o,
  input logic [IRQ_W-1:0]  flag_q,
  input logic [1:0]        stat_lo
);
  p_sleep_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_rst |=> $stable(mode_sleep));

  p_btime_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_rst |=> $stable(btime_o));

  p_cmd_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse_o != '0) |-> $past(bus_we && (bus_addr == A_CMD)));

  p_cmd_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_pulse_o != '0) && !(bus_we && (bus_addr == A_CMD))) |=> (cmd_pulse_o == '0));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !bus_we) |=> irq_o);

  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  p_rx_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[IB_RX] |=> stat_lo[0]);

  p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[IB_OVR] |=> stat_lo[1]);

  p_ec_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rst && !ec_load_i) |=> ($stable(tec_o) && $stable(rec_o)));
endmodule

bind canc_csr canc_csr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .evt_i       (evt_i),
  .ec_load_i   (ec_load_i),
  .mode_rst    (mode_o[0]),
  .mode_sleep  (mode_o[4]),
  .btime_o     (btime_o),
  .cmd_pulse_o (cmd_pulse_o),
  .tec_o       (tec_o),
  .rec_o       (rec_o),
  .irq_o       (irq_o),
  .flag_q      (flag_q),
  .stat_lo     (stat_q[1:0])
);

// File: tb/canc_csr_tb_top.sv
`timescale 1ns/1ps
module canc_csr_tb_top;
  localparam int S_BUS = 0, S_CMD = 1, S_IRQ = 2, S_MODE = 3, S_TEC = 4, S_REC = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_i = '0;
  logic [5:0]  eng_live_i = 6'b001111;
  logic        eng_rx_more_i = 1'b0;
  logic [4:0]  err_seg_i = '0;
  logic        err_dir_i = 1'b0;
  logic [1:0]  err_type_i = '0;
  logic        ec_load_i = 1'b0;
  logic [7:0]  ec_tx_i = '0, ec_rx_i = '0;
  logic [4:0]  mode_o;
  logic [31:0] btime_o;
  logic [5:0]  cmd_pulse_o;
  logic [7:0]  tec_o, rec_o;
  logic        irq_o;

  always #2 clk = ~clk;

  canc_csr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .eng_live_i(eng_live_i), .eng_rx_more_i(eng_rx_more_i),
    .err_seg_i(err_seg_i), .err_dir_i(err_dir_i), .err_type_i(err_type_i),
    .ec_load_i(ec_load_i), .ec_tx_i(ec_tx_i), .ec_rx_i(ec_rx_i),
    .mode_o(mode_o), .btime_o(btime_o), .cmd_pulse_o(cmd_pulse_o),
    .tec_o(tec_o), .rec_o(rec_o), .irq_o(irq_o)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;

  item_t sbq[$];
  event  chk_ev;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;

  // Monitor: pops expected items and compares against the live outputs.
  initial begin
    forever begin
      @(chk_ev);
      #0.2;
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        case (it.sel)
          S_BUS:   act = bus_rdata;
          S_CMD:   act = {26'b0, cmd_pulse_o};
          S_IRQ:   act = {31'b0, irq_o};
          S_MODE:  act = {27'b0, mode_o};
          S_TEC:   act = {24'b0, tec_o};
          default: act = {24'b0, rec_o};
        endcase
        n_chk++;
        if (((act ^ it.exp) & it.mask) != 0) begin
          n_err++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  // Driver side: push an expectation and wait until the monitor consumed it.
  task automatic expect_now(input int sel, input logic [7:0] a, input logic [31:0] e,
                            input logic [31:0] m, input string tag);
    item_t it;
    if (sel == S_BUS) bus_addr = a;
    it.sel = sel; it.exp = e; it.mask = m; it.tag = tag;
    sbq.push_back(it);
    ->chk_ev;
    wait (sbq.size() == 0);
    #0.3;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input logic [31:0] m,
                           input string tag);
    @(negedge clk);
    expect_now(S_BUS, a, e, m, tag);
  endtask

  task automatic expect_pin(input int sel, input logic [31:0] e, input string tag);
    @(negedge clk);
    expect_now(sel, 8'h00, e, 32'hFFFF_FFFF, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; evt_i = ev;
    @(negedge clk);
    bus_we = 1'b0; evt_i = '0;
  endtask

  task automatic pulse_evt(input logic [7:0] ev);
    @(negedge clk);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
  endtask

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(8'h00, 32'h1, ALL, "R1 mode");
    expect_rd(8'h08, 32'h3C, ALL, "R1 status");
    expect_rd(8'h0C, 32'h0, ALL, "R1 flags");
    expect_rd(8'h10, 32'h0, ALL, "R1 enable");
    expect_rd(8'h14, 32'h0, ALL, "R1 btime");
    expect_rd(8'h1C, 32'h0, ALL, "R1 errcnt");
    expect_rd(8'h04, 32'h0, ALL, "R1 cmd read");
    expect_pin(S_IRQ, 32'h0, "R1 irq");
    expect_pin(S_CMD, 32'h0, "R1 pulse");

    // R3 bit timing in configuration mode
    wr(8'h14, 32'h00A5_1234);
    expect_rd(8'h14, 32'h00A5_1234, ALL, "R3 btime write");

    // R12 software write and clear in configuration mode
    wr(8'h1C, 32'h0033_0011);
    expect_rd(8'h1C, 32'h0033_0011, ALL, "R12 errcnt write");
    expect_pin(S_TEC, 32'h11, "R12 tec");
    expect_pin(S_REC, 32'h33, "R12 rec");
    wr(8'h1C, 32'h0);
    expect_rd(8'h1C, 32'h0, ALL, "R12 zero clears");

    // R2 sleep lock
    wr(8'h00, 32'h11);
    expect_rd(8'h00, 32'h11, ALL, "R2 sleep in cfg");
    wr(8'h00, 32'h06);
    expect_rd(8'h00, 32'h06, ALL, "R2 leave cfg");
    wr(8'h00, 32'h16);
    expect_rd(8'h00, 32'h06, ALL, "R2 sleep ignored");
    wr(8'h00, 32'h0E);
    expect_pin(S_MODE, 32'h0E, "R2 mode_o");

    // R3 ignored outside configuration mode
    wr(8'h14, 32'hFFFF_FFFF);
    expect_rd(8'h14, 32'h00A5_1234, ALL, "R3 btime locked");

    // R12 ignored write, then engine load
    wr(8'h1C, 32'h0005_0007);
    expect_rd(8'h1C, 32'h0, ALL, "R12 errcnt locked");
    @(negedge clk);
    ec_load_i = 1'b1; ec_tx_i = 8'h20; ec_rx_i = 8'h40;
    @(negedge clk);
    ec_load_i = 1'b0;
    expect_now(S_BUS, 8'h1C, 32'h0040_0020, ALL, "R12 engine load");
    expect_now(S_TEC, 8'h00, 32'h20, ALL, "R12 tec load");

    // R4 command pulses
    wr(8'h04, 32'h21);
    expect_now(S_CMD, 8'h00, 32'h21, ALL, "R4 pulse high");
    expect_pin(S_CMD, 32'h0, "R4 pulse one cycle");
    wr(8'h04, 32'h3F);
    expect_now(S_CMD, 8'h00, 32'h3F, ALL, "R4 all bits");
    expect_rd(8'h04, 32'h0, ALL, "R4 cmd reads zero");

    // R5 sticky flags, R7 masked
    pulse_evt(8'h41);
    expect_now(S_BUS, 8'h0C, 32'h41, ALL, "R5 flags set");
    repeat (3) @(negedge clk);
    expect_rd(8'h0C, 32'h41, ALL, "R5 flags held");
    expect_pin(S_IRQ, 32'h0, "R7 irq masked");

    // R7 enable, R6 clear
    wr(8'h10, 32'h40);
    expect_now(S_IRQ, 8'h00, 32'h1, ALL, "R7 irq on");
    wr(8'h0C, 32'h40);
    expect_now(S_BUS, 8'h0C, 32'h01, ALL, "R6 clear one flag");
    expect_now(S_IRQ, 8'h00, 32'h0, ALL, "R7 irq off");
    wr(8'h10, 32'h01);
    expect_now(S_IRQ, 8'h00, 32'h1, ALL, "R7 irq other bit");

    // R6 event beats clear; R11 capture
    err_seg_i = 5'h19; err_dir_i = 1'b1; err_type_i = 2'd2;
    wr_evt(8'h0C, 32'h81, 8'h80);
    expect_now(S_BUS, 8'h0C, 32'h80, ALL, "R6 event wins");
    expect_now(S_IRQ, 8'h00, 32'h0, ALL, "R7 irq after clear");
    expect_rd(8'h08, 32'h00B9_003D, ALL, "R11 capture stuff rx");

    // R8 live status
    @(negedge clk);
    eng_live_i = 6'b110001;
    @(negedge clk);
    expect_now(S_BUS, 8'h08, 32'h0000_00C5, 32'h0000_00FF, "R8 live bits");

    // R9 release behaviour
    eng_rx_more_i = 1'b1;
    wr(8'h04, 32'h04);
    expect_now(S_BUS, 8'h08, 32'h1, 32'h1, "R9 release kept pending");
    eng_rx_more_i = 1'b0;
    wr(8'h04, 32'h04);
    expect_now(S_BUS, 8'h08, 32'h0, 32'h1, "R9 release clears");
    wr_evt(8'h04, 32'h04, 8'h01);
    expect_now(S_BUS, 8'h08, 32'h1, 32'h1, "R9 store beats release");

    // R10 overrun
    pulse_evt(8'h08);
    expect_now(S_BUS, 8'h08, 32'h2, 32'h2, "R10 overrun set");
    wr(8'h04, 32'h08);
    expect_now(S_BUS, 8'h08, 32'h0, 32'h2, "R10 overrun cleared");

    // R11 other codes, held between errors
    err_seg_i = 5'h03; err_dir_i = 1'b0; err_type_i = 2'd0;
    pulse_evt(8'h80);
    expect_now(S_BUS, 8'h08, 32'h0003_0000, 32'h00FF_0000, "R11 bit error tx");
    err_seg_i = 5'h1F; err_dir_i = 1'b1; err_type_i = 2'd3;
    expect_rd(8'h08, 32'h0003_0000, 32'h00FF_0000, "R11 held");
    pulse_evt(8'h80);
    expect_now(S_BUS, 8'h08, 32'h00FF_0000, 32'h00FF_0000, "R11 other rx");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule